// File: doc/BRIEF.md
# ECC Aggregator Interrupt Register Block

This block holds the software-visible control and status registers for an ECC error aggregator that looks after four protected RAMs. Correctable (SEC) and uncorrectable (DED) error events from each RAM are captured as sticky pending bits. Each error class has its own enable mask, which is changed through a pair of addresses: one sets mask bits and the other clears them. Each class drives a one-cycle interrupt pulse when its enabled pending set first becomes non-empty. Software can request a fresh pulse by writing an end-of-interrupt (EOI) register once it has finished servicing, so work that is still outstanding is not lost.

Aggregator-internal parity and timeout errors are tracked in small saturating counters. Software raises a counter with a write to one address and lowers it with a write to another. A level interrupt follows the enabled counters. A vector register selects a RAM and a read address and starts a read over an external serial port. It then reports completion when that port acknowledges. The block sits on a simple 32-bit register bus: a write strobe, an address and write data, and read data that follows the address combinationally.

Top module: `ecc_irq_regs`

## Requirements
- R1: After reset every register field is zero, every output is low, and every readable register returns zero except the source-count register.
- R2: Offset 0x00C returns the number of serviced RAMs (4) in bits 10:0 and zero elsewhere. Writes to it have no effect.
- R3: Each class has a pending register, at 0x040 for SEC and 0x140 for DED, with one bit per RAM in bits 3:0. A bit is set by the matching event input or by software writing 1 to it. Writing 0 has no effect. Bits stay set until reset.
- R4: The class enable mask is set by writing 1s to 0x080 (SEC) or 0x180 (DED). It is cleared by writing 1s to 0x0C0 (SEC) or 0x1C0 (DED). Both addresses of a class read back the current mask in bits 3:0.
- R5: A class pulse output is high for exactly one cycle, in the cycle after the OR of (pending AND enable) goes from 0 to 1. It does not fire again while that OR stays 1.
- R6: A write with bit 0 set to 0x03C (SEC) or 0x13C (DED) gives a one-cycle pulse in the next cycle if the class's enabled pending OR is 1. A write with bit 0 clear, or a write while the OR is 0, gives no pulse. A rise and an EOI in the same cycle give a single pulse. EOI addresses read as zero.
- R7: The parity count sits in bits 1:0 and the timeout count in bits 3:2. A write to 0x208 increments each count whose written field is nonzero, saturating at 3. A write to 0x20C decrements each such count, stopping at 0. Both addresses read the counts at those positions.
- R8: The aggregator enable mask (bit 0 parity, bit 1 timeout) is set through 0x200 and cleared through 0x204, and both addresses read it back. aggr_irq is high while any enabled count is nonzero.
- R9: At 0x008, bits 10:0 hold the RAM select and bits 23:16 the read address. Both are written directly and read back. Writing 1 to bit 15 sets the trigger bit, which drives rd_req, with rd_req_ram and rd_req_addr carrying the fields. Bits 14:11 and 31:25 read 0.
- R10: rd_ack while the trigger is set clears the trigger and sets the done bit 24 in the next cycle. Any write to 0x008 clears done, but an acknowledge in the same cycle wins. rd_ack without a trigger is ignored.
- R11: Reads of unlisted offsets return zero, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| sec_evt | input | 4 | Correctable-error event per RAM |
| ded_evt | input | 4 | Uncorrectable-error event per RAM |
| sec_pulse | output | 1 | SEC interrupt pulse |
| ded_pulse | output | 1 | DED interrupt pulse |
| aggr_irq | output | 1 | Level interrupt for enabled nonzero counts |
| rd_req | output | 1 | Serial read request |
| rd_req_ram | output | 11 | RAM selected for the serial read |
| rd_req_addr | output | 8 | Address of the serial read |
| rd_ack | input | 1 | Serial read acknowledge |

## Verification
Two collisions are provoked on purpose. In the first, an event arrives on the DED input and the EOI write is issued in the very cycle in which the enabled pending OR rises; the bench counts pulses over the following cycles and accepts exactly one. In the second, the serial acknowledge coincides with an ordinary write to the vector register; the read-back must show the done bit set, the trigger cleared and the new select and address fields in place. The counters and enable masks are swept over every 4-bit write value and every enable combination, with expected counts and interrupt levels computed arithmetically in the bench.

// File: rtl/ecc_irq_pkg.sv
package ecc_irq_pkg;

   // register offsets (byte addresses)
   localparam int OFS_VECTOR     = 'h008;
   localparam int OFS_INFO       = 'h00C;
   localparam int OFS_EOI        = 'h03C;
   localparam int OFS_PEND       = 'h040;
   localparam int OFS_EN_SET     = 'h080;
   localparam int OFS_EN_CLR     = 'h0C0;
   localparam int CLASS_STRIDE   = 'h100;
   localparam int OFS_AGG_EN_SET = 'h200;
   localparam int OFS_AGG_EN_CLR = 'h204;
   localparam int OFS_AGG_INC    = 'h208;
   localparam int OFS_AGG_DEC    = 'h20C;

   // structure
   localparam int NUM_CLASS = 2;   // 0: correctable, 1: uncorrectable
   localparam int NUM_AGG   = 2;   // 0: parity, 1: timeout
   localparam int INFO_W    = 11;

   // vector register field positions
   localparam int VEC_TRIG_BIT = 15;
   localparam int VEC_ADDR_LSB = 16;
   localparam int VEC_DONE_BIT = 24;

endpackage

// File: rtl/ecc_pend_class.sv
module ecc_pend_class #(
   parameter int NSRC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] hw_evt,
   input  logic            pend_we,
   input  logic            en_set_we,
   input  logic            en_clr_we,
   input  logic            eoi_we,
   input  logic [NSRC-1:0] wbits,
   input  logic            eoi_bit,
   output logic [NSRC-1:0] pend_o,
   output logic [NSRC-1:0] en_o,
   output logic            pulse_o
);

   logic active;
   logic active_q;
   logic pulse_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic p_q;
      logic e_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= 1'b0;
            e_q <= 1'b0;
         end else begin
            p_q <= p_q | hw_evt[i] | (pend_we & wbits[i]);
            if (en_set_we && wbits[i]) begin
               e_q <= 1'b1;
            end else if (en_clr_we && wbits[i]) begin
               e_q <= 1'b0;
            end
         end
      end
      assign pend_o[i] = p_q;
      assign en_o[i]   = e_q;
   end

   assign active = |(pend_o & en_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         pulse_q  <= 1'b0;
      end else begin
         active_q <= active;
         pulse_q  <= (active & ~active_q) | (eoi_we & eoi_bit & active);
      end
   end

   assign pulse_o = pulse_q;

   // R3: pending bits never drop once set
   a_r3_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

   // R5: a pulse always has an enabled pending source behind it
   a_r5_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> $past(active));

   // R5: a rise of the enabled OR is always followed by a pulse
   a_r5_rise_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !active_q) |=> pulse_o);

   // R6: an EOI write that finds the OR high re-fires the pulse
   a_r6_eoi_refires: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_we && eoi_bit && active) |=> pulse_o);

endmodule

// File: rtl/ecc_sat_cnt.sv
module ecc_sat_cnt #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc) begin
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end else if (dec) begin
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   // R7: the count moves by at most one step and never wraps
   a_r7_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((int'(cnt_q) - int'($past(cnt_q)) <= 1) &&
                (int'($past(cnt_q)) - int'(cnt_q) <= 1)));

   // R7: without a command the count holds
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !dec) |=> $stable(cnt_q));

endmodule

// File: rtl/ecc_vec_ctl.sv
module ecc_vec_ctl #(
   parameter int SEL_W   = 11,
   parameter int RADDR_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [SEL_W-1:0]   sel_in,
   input  logic [RADDR_W-1:0] addr_in,
   input  logic               trig_in,
   input  logic               ack,
   output logic [SEL_W-1:0]   sel_o,
   output logic [RADDR_W-1:0] addr_o,
   output logic               trig_o,
   output logic               done_o
);

   logic [SEL_W-1:0]   sel_q;
   logic [RADDR_W-1:0] addr_q;
   logic               trig_q;
   logic               done_q;
   logic               finish;

   assign finish = trig_q & ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         addr_q <= '0;
         trig_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (wr) begin
            sel_q  <= sel_in;
            addr_q <= addr_in;
         end
         if (finish) begin
            trig_q <= 1'b0;
         end else if (wr && trig_in) begin
            trig_q <= 1'b1;
         end
         if (finish) begin
            done_q <= 1'b1;
         end else if (wr) begin
            done_q <= 1'b0;
         end
      end
   end

   assign sel_o  = sel_q;
   assign addr_o = addr_q;
   assign trig_o = trig_q;
   assign done_o = done_q;

   // R10: an acknowledge during a request completes it
   a_r10_ack_completes: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_q && ack) |=> (!trig_q && done_q));

   // R10: done only rises from an acknowledged request
   a_r10_done_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(trig_q && ack));

   // R9: a trigger write on an idle port raises the request
   a_r9_start: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && trig_in && !trig_q) |=> trig_q);

endmodule

// File: rtl/ecc_irq_regs.sv
module ecc_irq_regs
   import ecc_irq_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12,
   parameter int SEL_W   = 11,
   parameter int RADDR_W = 8,
   parameter int CNT_W   = 2,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] sec_evt,
   input  logic [NUM_SRC-1:0] ded_evt,
   output logic               sec_pulse,
   output logic               ded_pulse,
   output logic               aggr_irq,
   output logic               rd_req,
   output logic [SEL_W-1:0]   rd_req_ram,
   output logic [RADDR_W-1:0] rd_req_addr,
   input  logic               rd_ack
);

   // elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > DATA_W || NUM_SRC >= (1 << INFO_W)) begin : g_bad_src
      $error("NUM_SRC out of range");
   end
   if (DATA_W <= VEC_DONE_BIT) begin : g_bad_dw
      $error("DATA_W too narrow for vector register");
   end
   if (SEL_W < 1 || SEL_W > VEC_TRIG_BIT) begin : g_bad_sel
      $error("SEL_W overlaps trigger bit");
   end
   if (RADDR_W < 1 || RADDR_W > VEC_DONE_BIT - VEC_ADDR_LSB) begin : g_bad_ra
      $error("RADDR_W overlaps done bit");
   end
   if (CNT_W < 1 || NUM_AGG * CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W out of range");
   end
   if (ADDR_W < 10) begin : g_bad_aw
      $error("ADDR_W too narrow for register map");
   end

   localparam logic [ADDR_W-1:0] A_VECTOR  = ADDR_W'(OFS_VECTOR);
   localparam logic [ADDR_W-1:0] A_INFO    = ADDR_W'(OFS_INFO);
   localparam logic [ADDR_W-1:0] A_AGG_ENS = ADDR_W'(OFS_AGG_EN_SET);
   localparam logic [ADDR_W-1:0] A_AGG_ENC = ADDR_W'(OFS_AGG_EN_CLR);
   localparam logic [ADDR_W-1:0] A_AGG_INC = ADDR_W'(OFS_AGG_INC);
   localparam logic [ADDR_W-1:0] A_AGG_DEC = ADDR_W'(OFS_AGG_DEC);

   function automatic logic [ADDR_W-1:0] cls_addr(input int base, input int cls);
      return ADDR_W'(base + cls * CLASS_STRIDE);
   endfunction

   logic wdata_unused;
   assign wdata_unused = ^reg_wdata[DATA_W-1:VEC_DONE_BIT+1];

   // ---------------- error classes ----------------
   logic [NUM_SRC-1:0] evt_arr  [NUM_CLASS];
   logic [NUM_SRC-1:0] pend_arr [NUM_CLASS];
   logic [NUM_SRC-1:0] en_arr   [NUM_CLASS];
   logic [NUM_CLASS-1:0] pulse_vec;

   assign evt_arr[0] = sec_evt;
   assign evt_arr[1] = ded_evt;

   for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
      logic pend_we, ens_we, enc_we, eoi_we;
      assign pend_we = reg_wr && (reg_addr == cls_addr(OFS_PEND, c));
      assign ens_we  = reg_wr && (reg_addr == cls_addr(OFS_EN_SET, c));
      assign enc_we  = reg_wr && (reg_addr == cls_addr(OFS_EN_CLR, c));
      assign eoi_we  = reg_wr && (reg_addr == cls_addr(OFS_EOI, c));

      ecc_pend_class #(.NSRC(NUM_SRC)) u_cls (
         .clk       (clk),
         .rst_n     (rst_n),
         .hw_evt    (evt_arr[c]),
         .pend_we   (pend_we),
         .en_set_we (ens_we),
         .en_clr_we (enc_we),
         .eoi_we    (eoi_we),
         .wbits     (reg_wdata[NUM_SRC-1:0]),
         .eoi_bit   (reg_wdata[0]),
         .pend_o    (pend_arr[c]),
         .en_o      (en_arr[c]),
         .pulse_o   (pulse_vec[c])
      );
   end

   assign sec_pulse = pulse_vec[0];
   assign ded_pulse = pulse_vec[1];

   // ---------------- aggregator counters ----------------
   logic [NUM_AGG-1:0] agg_en_q;
   logic [CNT_W-1:0]   agg_cnt [NUM_AGG];
   logic [NUM_AGG-1:0] agg_nz;
   logic               irq_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         agg_en_q <= '0;
      end else if (reg_wr && reg_addr == A_AGG_ENS) begin
         agg_en_q <= agg_en_q | reg_wdata[NUM_AGG-1:0];
      end else if (reg_wr && reg_addr == A_AGG_ENC) begin
         agg_en_q <= agg_en_q & ~reg_wdata[NUM_AGG-1:0];
      end
   end

   for (genvar f = 0; f < NUM_AGG; f++) begin : g_agg
      logic inc, dec;
      assign inc = reg_wr && (reg_addr == A_AGG_INC) && (|reg_wdata[f*CNT_W +: CNT_W]);
      assign dec = reg_wr && (reg_addr == A_AGG_DEC) && (|reg_wdata[f*CNT_W +: CNT_W]);

      ecc_sat_cnt #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc),
         .dec   (dec),
         .cnt_o (agg_cnt[f])
      );
      assign agg_nz[f] = |agg_cnt[f];
   end

   assign irq_now = |(agg_en_q & agg_nz);

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_now;
      end
      assign aggr_irq = irq_q;
   end else begin : g_irq_comb
      assign aggr_irq = irq_now;
   end

   // ---------------- serial read vector ----------------
   logic vec_we, trig_q, done_q;

   assign vec_we = reg_wr && (reg_addr == A_VECTOR);

   ecc_vec_ctl #(.SEL_W(SEL_W), .RADDR_W(RADDR_W)) u_vec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (vec_we),
      .sel_in  (reg_wdata[SEL_W-1:0]),
      .addr_in (reg_wdata[VEC_ADDR_LSB +: RADDR_W]),
      .trig_in (reg_wdata[VEC_TRIG_BIT]),
      .ack     (rd_ack),
      .sel_o   (rd_req_ram),
      .addr_o  (rd_req_addr),
      .trig_o  (trig_q),
      .done_o  (done_q)
   );

   assign rd_req = trig_q;

   // ---------------- read mux ----------------
   logic addr_hit;

   always_comb begin
      reg_rdata = '0;
      addr_hit  = 1'b0;
      if (reg_addr == A_VECTOR) begin
         addr_hit = 1'b1;
         reg_rdata[SEL_W-1:0]                = rd_req_ram;
         reg_rdata[VEC_ADDR_LSB +: RADDR_W]  = rd_req_addr;
         reg_rdata[VEC_TRIG_BIT]             = trig_q;
         reg_rdata[VEC_DONE_BIT]             = done_q;
      end
      if (reg_addr == A_INFO) begin
         addr_hit = 1'b1;
         reg_rdata[INFO_W-1:0] = INFO_W'(NUM_SRC);
      end
      for (int c = 0; c < NUM_CLASS; c++) begin
         if (reg_addr == cls_addr(OFS_EOI, c)) begin
            addr_hit = 1'b1;
         end
         if (reg_addr == cls_addr(OFS_PEND, c)) begin
            addr_hit = 1'b1;
            reg_rdata[NUM_SRC-1:0] = pend_arr[c];
         end
         if (reg_addr == cls_addr(OFS_EN_SET, c) || reg_addr == cls_addr(OFS_EN_CLR, c)) begin
            addr_hit = 1'b1;
            reg_rdata[NUM_SRC-1:0] = en_arr[c];
         end
      end
      if (reg_addr == A_AGG_ENS || reg_addr == A_AGG_ENC) begin
         addr_hit = 1'b1;
         reg_rdata[NUM_AGG-1:0] = agg_en_q;
      end
      if (reg_addr == A_AGG_INC || reg_addr == A_AGG_DEC) begin
         addr_hit = 1'b1;
         for (int f = 0; f < NUM_AGG; f++) begin
            reg_rdata[f*CNT_W +: CNT_W] = agg_cnt[f];
         end
      end
   end

   // R11: writes to unlisted offsets leave every stored field alone
   a_r11_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !addr_hit && !rd_ack) |=> ($stable(agg_en_q) && $stable(rd_req_ram) &&
                                              $stable(rd_req_addr) && $stable(done_q)));

   // R8: the aggregator level interrupt needs an enabled nonzero count
   a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (aggr_irq && !IRQ_REG) |-> (|agg_nz));

   // R2: the source count register is constant
   a_r2_info_const: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_INFO) |-> (reg_rdata == DATA_W'(NUM_SRC)));

endmodule

// File: tb/ecc_irq_regs_bench.sv
module ecc_irq_regs_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  sec_evt = '0;
   logic [3:0]  ded_evt = '0;
   logic        sec_pulse, ded_pulse, aggr_irq, rd_req, rd_ack = 1'b0;
   logic [10:0] rd_req_ram;
   logic [7:0]  rd_req_addr;

   int n_chk = 0;
   int n_fail = 0;
   int sec_cnt = 0;
   int ded_cnt = 0;
   bit done_flag = 0;

   ecc_irq_regs u_ecc_irq_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_evt(sec_evt),
      .ded_evt(ded_evt), .sec_pulse(sec_pulse), .ded_pulse(ded_pulse),
      .aggr_irq(aggr_irq), .rd_req(rd_req), .rd_req_ram(rd_req_ram),
      .rd_req_addr(rd_req_addr), .rd_ack(rd_ack)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (sec_pulse) sec_cnt++;
      if (ded_pulse) ded_cnt++;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int mp, mt, base, pm, em;
      int seq [6] = '{0, 1, 0, 4, 2, 8};

      do_reset();
      // R1 / R2: reset state
      begin
         int offs [12] = '{'h008, 'h03C, 'h040, 'h080, 'h0C0, 'h13C, 'h140,
                           'h180, 'h1C0, 'h200, 'h204, 'h208};
         foreach (offs[i]) begin
            rd(offs[i][11:0], d);
            chk("R1 reset readback", d, 32'h0);
         end
      end
      chk("R1 outputs low", {28'h0, sec_pulse, ded_pulse, aggr_irq, rd_req}, 32'h0);
      rd(12'h00C, d);
      chk("R2 source count", d, 32'h4);
      wr(12'h00C, 32'hFFFF_FFFF);
      rd(12'h00C, d);
      chk("R2 count after write", d, 32'h4);

      // R3: software pending sweep on SEC (enables 0 -> no pulses)
      pm = 0;
      foreach (seq[i]) begin
         wr(12'h040, seq[i]);
         pm = pm | seq[i];
         rd(12'h040, d);
         chk("R3 sw pending", d, pm);
      end
      chk("R3 no pulse while disabled", sec_cnt, 0);

      // R3: hardware event on DED
      @(negedge clk); ded_evt = 4'h5;
      @(negedge clk); ded_evt = 4'h0;
      rd(12'h140, d);
      chk("R3 hw pending", d, 32'h5);
      wr(12'h140, 32'h0);
      rd(12'h140, d);
      chk("R3 write zero ignored", d, 32'h5);

      // R4: enable sweep on DED via clear/set, both addresses
      do_reset();
      em = 0;
      for (int v = 0; v < 16; v++) begin
         wr(12'h180, v);
         em = em | v;
         rd(12'h180, d);
         chk("R4 enable set", d, em);
         wr(12'h1C0, (v * 5) & 15);
         em = em & ~((v * 5) & 15);
         rd(12'h1C0, d);
         chk("R4 enable clr readback", d, em);
      end

      // R5 / R6 on SEC
      do_reset();
      sec_cnt = 0;
      wr(12'h080, 32'h1);
      @(negedge clk); sec_evt = 4'h4;
      @(negedge clk); sec_evt = 4'h0;
      idle(3);
      chk("R5 disabled source no pulse", sec_cnt, 0);
      @(negedge clk); sec_evt = 4'h1;
      @(negedge clk); sec_evt = 4'h0;
      idle(3);
      chk("R5 single pulse on rise", sec_cnt, 1);
      @(negedge clk); sec_evt = 4'h1;
      @(negedge clk); sec_evt = 4'h0;
      idle(3);
      chk("R5 no refire while high", sec_cnt, 1);
      wr(12'h03C, 32'h1);
      idle(3);
      chk("R6 eoi refires", sec_cnt, 2);
      wr(12'h03C, 32'h2);
      idle(3);
      chk("R6 eoi bit0 clear no pulse", sec_cnt, 2);
      rd(12'h03C, d);
      chk("R6 eoi reads zero", d, 32'h0);
      wr(12'h0C0, 32'h1);
      wr(12'h03C, 32'h1);
      idle(3);
      chk("R6 eoi while inactive", sec_cnt, 2);
      wr(12'h080, 32'h4);
      idle(3);
      chk("R5 rise through enable", sec_cnt, 3);

      // R6: rise and EOI in the same cycle on DED
      ded_cnt = 0;
      wr(12'h180, 32'h8);
      @(negedge clk); ded_evt = 4'h8;
      @(negedge clk); ded_evt = 4'h0;
      reg_wr = 1'b1; reg_addr = 12'h13C; reg_wdata = 32'h1;
      @(negedge clk); reg_wr = 1'b0;
      idle(4);
      chk("R6 coincident rise and eoi single pulse", ded_cnt, 1);
      wr(12'h13C, 32'h1);
      idle(3);
      chk("R6 ded eoi later", ded_cnt, 2);

      // R7 / R8: counter sweep with enable combinations
      do_reset();
      mp = 0; mt = 0;
      for (int pass = 0; pass < 2; pass++) begin
         for (int v = 0; v < 16; v++) begin
            wr(pass == 0 ? 12'h208 : 12'h20C, v);
            if ((v & 3) != 0) mp = (pass == 0) ? ((mp < 3) ? mp + 1 : 3) : ((mp > 0) ? mp - 1 : 0);
            if ((v & 12) != 0) mt = (pass == 0) ? ((mt < 3) ? mt + 1 : 3) : ((mt > 0) ? mt - 1 : 0);
            rd(12'h208, d);
            chk("R7 count at inc addr", d, (mt << 2) | mp);
            rd(12'h20C, d);
            chk("R7 count at dec addr", d, (mt << 2) | mp);
            for (int e = 0; e < 4; e++) begin
               wr(12'h204, 32'h3);
               wr(12'h200, e);
               rd(12'h204, d);
               chk("R8 enable readback", d, e);
               chk("R8 level irq", {31'h0, aggr_irq},
                   (((e & 1) != 0 && mp != 0) || ((e & 2) != 0 && mt != 0)) ? 1 : 0);
            end
         end
      end

      // R9 / R10: serial read vector
      do_reset();
      wr(12'h008, 32'h00A5_8003);
      rd(12'h008, d);
      chk("R9 vector readback", d, 32'h00A5_8003);
      chk("R9 request outputs", {12'h0, rd_req, rd_req_addr, rd_req_ram}, {12'h0, 1'b1, 8'hA5, 11'h003});
      @(negedge clk); rd_ack = 1'b1;
      @(negedge clk); rd_ack = 1'b0;
      rd(12'h008, d);
      chk("R10 ack completes", d, 32'h01A5_0003);
      chk("R10 request drops", {31'h0, rd_req}, 0);
      wr(12'h008, 32'h00A5_0003);
      rd(12'h008, d);
      chk("R10 write clears done", d, 32'h00A5_0003);
      @(negedge clk); rd_ack = 1'b1;
      @(negedge clk); rd_ack = 1'b0;
      rd(12'h008, d);
      chk("R10 stray ack ignored", d, 32'h00A5_0003);
      wr(12'h008, 32'h0000_8001);
      @(negedge clk);
      rd_ack = 1'b1; reg_wr = 1'b1; reg_addr = 12'h008; reg_wdata = 32'h0011_0007;
      @(negedge clk);
      rd_ack = 1'b0; reg_wr = 1'b0;
      rd(12'h008, d);
      chk("R10 ack beats write", d, 32'h0111_0007);
      wr(12'h008, 32'hFFFF_FFFF);
      rd(12'h008, d);
      chk("R9 reserved bits zero", d, 32'h00FF_87FF);

      // R11: unlisted offsets
      wr(12'h200, 32'h1);
      wr(12'h208, 32'h1);
      base = sec_cnt;
      begin
         int bad [5] = '{'h000, 'h004, 'h044, 'h210, 'h3FC};
         foreach (bad[i]) begin
            wr(bad[i][11:0], 32'hFFFF_FFFF);
            rd(bad[i][11:0], d);
            chk("R11 unlisted reads zero", d, 32'h0);
         end
      end
      rd(12'h008, d);
      chk("R11 vector untouched", d, 32'h00FF_87FF);
      rd(12'h208, d);
      chk("R11 counts untouched", d, 32'h1);
      rd(12'h200, d);
      chk("R11 agg enable untouched", d, 32'h1);
      rd(12'h040, d);
      chk("R11 pending untouched", d, 32'h0);
      chk("R11 no pulse", sec_cnt, base);

      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule